// File: doc/BRIEF.md
# Trap Arbitration and Reset Controller

This block sits next to the interrupt controller of a small 16-bit core. It gathers non-maskable trap requests and reset-cause inputs. Each trap request is one bit of a vector, and the bit index is the trap's rank. A request is held as pending until the instruction that raised it completes. The block then grants the highest-ranked pending trap. It emits a vector index with a one-cycle strobe and raises the processor priority level into the trap band, levels 8 to 15.

Two or more trap conditions arriving in the same cycle are not nested. The block escalates them to a device reset and records a lockout cause. A watchdog timeout, a brown-out, an uninitialized address pointer and an executed illegal opcode also force a device reset. An illegal opcode whose instruction was flushed by a flow change is ignored. Every device reset and every power-on reset pulses a strobe that loads the program counter with zero. A sticky cause register records which source fired, and software clears it bit by bit.

Top module: `trap_rst_ctrl`

## Requirements
- R1: While and right after power-on reset (`rst_ni` low), `take_trap_o` and `dev_rst_o` are 0, `ipl_o` is 0 and `cause_o` is 0. `pc_zero_o` is 1 until the first clock edge after release.
- R2: A single request bit `trap_req_i[k]` becomes pending at the next edge. The pending trap is granted at the first later edge where `instr_done_i` is 1. The following cycle has `take_trap_o`=1 for exactly one cycle with `trap_vec_o`=k.
- R3: On a grant, `ipl_o` becomes 8+k, so `ipl_o[3]` is 1 while a trap is serviced.
- R4: When several traps are pending from different cycles, the highest bit index is granted first. The others stay pending and are granted on later `instr_done_i` edges.
- R5: Traps are granted whatever the software level, including level 7. A software level write (`ipl_we_i`, 3-bit `ipl_wdata_i`) sets `ipl_o` only while `ipl_o[3]` is 0, and is ignored while a trap is being serviced.
- R6: `trap_ret_i` restores the level held before entry from a non-trap level, even after nested grants. It has no effect while `ipl_o[3]` is 0.
- R7: If two or more `trap_req_i` bits are 1 in the same cycle, the next cycle has `dev_rst_o`=1 and cause bit 4 (lockout) set.
- R8: Watchdog (`wdt_timeout_i`, cause bit 0), uninitialized pointer (`uninit_ptr_i`, bit 1), executed illegal opcode (`illegal_op_i`, bit 2) and brown-out (`bor_i`, bit 3) each give a one-cycle `dev_rst_o` pulse in the following cycle and set their cause bit.
- R9: `illegal_op_i` is ignored in a cycle where `flush_i` is 1: no reset and no cause bit.
- R10: While `dev_rst_o` is 1, `pc_zero_o` is 1, `ipl_o` is 0 and `take_trap_o` is 0. The device reset discards all pending traps, including requests and grants in the same cycle.
- R11: Cause bits are sticky. Bit i is cleared by `cause_clr_i[i]`, a set in the same cycle wins over the clear, and a device reset does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| trap_req_i | input | NUM_TRAPS | Trap conditions, bit k is trap level 8+k |
| instr_done_i | input | 1 | Offending instruction has completed |
| illegal_op_i | input | 1 | Illegal opcode reached execution |
| flush_i | input | 1 | Current instruction flushed by a flow change |
| uninit_ptr_i | input | 1 | Uninitialized register used as address pointer |
| wdt_timeout_i | input | 1 | Watchdog timeout |
| bor_i | input | 1 | Brown-out detected |
| trap_ret_i | input | 1 | Return-from-trap pulse |
| ipl_we_i | input | 1 | Software level write strobe |
| ipl_wdata_i | input | 3 | Software level, 0 to 7 |
| cause_clr_i | input | 5 | Per-bit clear of the cause register |
| take_trap_o | output | 1 | Trap grant strobe |
| trap_vec_o | output | VEC_W | Index of the granted trap |
| ipl_o | output | 4 | Current processor priority level |
| dev_rst_o | output | 1 | Device reset pulse |
| pc_zero_o | output | 1 | Load program counter with zero |
| cause_o | output | 5 | Sticky reset causes |

## Verification
The bench builds the block with NUM_TRAPS at its default of 8. With that value every level from 8 to 15 can be granted, and the highest index can be pitted against lower ones. Lockout is reached with two simultaneous bits. Grants are mixed with reset sources in the same cycle, so the case where a reset discards a grant is covered.

// File: rtl/trap_rst_pkg.sv
package trap_rst_pkg;
  localparam int unsigned NUM_CAUSES = 5;
  localparam int unsigned IPL_W      = 4;
  localparam logic [IPL_W-1:0] IPL_TRAP_BASE = 4'd8;

  typedef enum int unsigned {
    CAUSE_WDT     = 0,
    CAUSE_UNINIT  = 1,
    CAUSE_ILLEGAL = 2,
    CAUSE_BOR     = 3,
    CAUSE_LOCKOUT = 4
  } cause_e;
endpackage

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  // later iterations override, so the highest index wins
  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o  = |req_i;
  assign onehot_o = valid_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/trap_cause_reg.sv
module trap_cause_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_rst_ctrl.sv
module trap_rst_ctrl
  import trap_rst_pkg::*;
#(
  parameter int unsigned NUM_TRAPS = 8,
  parameter int unsigned VEC_W     = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_TRAPS-1:0]  trap_req_i,
  input  logic                  instr_done_i,
  input  logic                  illegal_op_i,
  input  logic                  flush_i,
  input  logic                  uninit_ptr_i,
  input  logic                  wdt_timeout_i,
  input  logic                  bor_i,
  input  logic                  trap_ret_i,
  input  logic                  ipl_we_i,
  input  logic [2:0]            ipl_wdata_i,
  input  logic [NUM_CAUSES-1:0] cause_clr_i,
  output logic                  take_trap_o,
  output logic [VEC_W-1:0]      trap_vec_o,
  output logic [IPL_W-1:0]      ipl_o,
  output logic                  dev_rst_o,
  output logic                  pc_zero_o,
  output logic [NUM_CAUSES-1:0] cause_o
);
  logic [NUM_TRAPS-1:0]  pend_q, pend_d, pick_oh;
  logic                  pick_valid;
  logic [VEC_W-1:0]      pick_idx;
  logic                  lockout_ev, illegal_ev, rst_ev, take_ev;
  logic [NUM_CAUSES-1:0] src_set;
  logic [IPL_W-1:0]      ipl_d, saved_q, saved_d;
  logic                  por_q;

  trap_prio_pick #(.N(NUM_TRAPS), .IDX_W(VEC_W)) u_pick (
    .req_i    (pend_q),
    .valid_o  (pick_valid),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  // two or more bits set in the same cycle
  assign lockout_ev = (trap_req_i & (trap_req_i - NUM_TRAPS'(1))) != '0;
  assign illegal_ev = illegal_op_i & ~flush_i;

  always_comb begin
    src_set                = '0;
    src_set[CAUSE_WDT]     = wdt_timeout_i;
    src_set[CAUSE_UNINIT]  = uninit_ptr_i;
    src_set[CAUSE_ILLEGAL] = illegal_ev;
    src_set[CAUSE_BOR]     = bor_i;
    src_set[CAUSE_LOCKOUT] = lockout_ev;
  end

  assign rst_ev  = |src_set;
  assign take_ev = ~rst_ev & instr_done_i & pick_valid;

  trap_cause_reg #(.W(NUM_CAUSES)) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set),
    .clr_i  (cause_clr_i),
    .q_o    (cause_o)
  );

  always_comb begin
    if (rst_ev) pend_d = '0;
    else        pend_d = (pend_q & ~(take_ev ? pick_oh : '0)) | trap_req_i;
  end

  always_comb begin
    ipl_d   = ipl_o;
    saved_d = saved_q;
    if (rst_ev) begin
      ipl_d   = '0;
      saved_d = '0;
    end else if (take_ev) begin
      ipl_d = IPL_TRAP_BASE + IPL_W'(pick_idx);
      if (!ipl_o[IPL_W-1]) saved_d = ipl_o;  // keep level from outside the trap band
    end else if (trap_ret_i && ipl_o[IPL_W-1]) begin
      ipl_d = saved_q;
    end else if (ipl_we_i && !ipl_o[IPL_W-1]) begin
      ipl_d = {1'b0, ipl_wdata_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      ipl_o       <= '0;
      saved_q     <= '0;
      take_trap_o <= 1'b0;
      trap_vec_o  <= '0;
      dev_rst_o   <= 1'b0;
      por_q       <= 1'b1;
    end else begin
      pend_q      <= pend_d;
      ipl_o       <= ipl_d;
      saved_q     <= saved_d;
      take_trap_o <= take_ev;
      trap_vec_o  <= take_ev ? pick_idx : trap_vec_o;
      dev_rst_o   <= rst_ev;
      por_q       <= 1'b0;
    end
  end

  assign pc_zero_o = por_q | dev_rst_o;
endmodule

// File: rtl/trap_rst_ctrl_chk.sv
module trap_rst_ctrl_chk
  import trap_rst_pkg::*;
#(
  parameter int unsigned NUM_TRAPS = 8,
  parameter int unsigned VEC_W     = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_TRAPS-1:0]  trap_req_i,
  input logic                  instr_done_i,
  input logic                  illegal_op_i,
  input logic                  flush_i,
  input logic                  uninit_ptr_i,
  input logic                  wdt_timeout_i,
  input logic                  bor_i,
  input logic [NUM_CAUSES-1:0] cause_clr_i,
  input logic                  take_trap_o,
  input logic [VEC_W-1:0]      trap_vec_o,
  input logic [IPL_W-1:0]      ipl_o,
  input logic                  dev_rst_o,
  input logic                  pc_zero_o,
  input logic [NUM_CAUSES-1:0] cause_o
);
  assert_grant_after_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trap_o |-> $past(instr_done_i));

  assert_trap_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trap_o |-> (ipl_o == IPL_TRAP_BASE + IPL_W'(trap_vec_o)));

  assert_lockout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(trap_req_i) > 1) |=> (dev_rst_o && cause_o[CAUSE_LOCKOUT]));

  assert_reset_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_timeout_i || uninit_ptr_i || bor_i) |=> dev_rst_o);

  assert_flushed_illegal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_op_i && flush_i && !wdt_timeout_i && !uninit_ptr_i && !bor_i &&
     ($countones(trap_req_i) <= 1)) |=> !dev_rst_o);

  assert_dev_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |-> (pc_zero_o && !take_trap_o && ipl_o == '0));

  assert_sticky_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cause_o) & ~cause_o & ~$past(cause_clr_i)) == '0));
endmodule

bind trap_rst_ctrl trap_rst_ctrl_chk #(.NUM_TRAPS(NUM_TRAPS), .VEC_W(VEC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trap_req_i    (trap_req_i),
  .instr_done_i  (instr_done_i),
  .illegal_op_i  (illegal_op_i),
  .flush_i       (flush_i),
  .uninit_ptr_i  (uninit_ptr_i),
  .wdt_timeout_i (wdt_timeout_i),
  .bor_i         (bor_i),
  .cause_clr_i   (cause_clr_i),
  .take_trap_o   (take_trap_o),
  .trap_vec_o    (trap_vec_o),
  .ipl_o         (ipl_o),
  .dev_rst_o     (dev_rst_o),
  .pc_zero_o     (pc_zero_o),
  .cause_o       (cause_o)
);

// File: tb/trap_rst_ctrl_tb.sv
module trap_rst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] trap_req_i = '0;
  logic          instr_done_i = 1'b0, illegal_op_i = 1'b0, flush_i = 1'b0;
  logic          uninit_ptr_i = 1'b0, wdt_timeout_i = 1'b0, bor_i = 1'b0;
  logic          trap_ret_i = 1'b0, ipl_we_i = 1'b0;
  logic [2:0]    ipl_wdata_i = '0;
  logic [4:0]    cause_clr_i = '0;
  logic          take_trap_o, dev_rst_o, pc_zero_o;
  logic [2:0]    trap_vec_o;
  logic [3:0]    ipl_o;
  logic [4:0]    cause_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string      req;
    logic       take;
    logic [2:0] vec;
    logic [3:0] ipl;
    logic       drst;
    logic [4:0] cause;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trap_rst_ctrl #(.NUM_TRAPS(NT)) u_dut (
    .clk_i, .rst_ni, .trap_req_i, .instr_done_i, .illegal_op_i, .flush_i,
    .uninit_ptr_i, .wdt_timeout_i, .bor_i, .trap_ret_i, .ipl_we_i, .ipl_wdata_i,
    .cause_clr_i, .take_trap_o, .trap_vec_o, .ipl_o, .dev_rst_o, .pc_zero_o, .cause_o
  );

  // monitor: compare after each edge
  always @(posedge clk_i) begin
    #2;
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      checks++;
      if (take_trap_o !== cur.take || (cur.take && trap_vec_o !== cur.vec) ||
          ipl_o !== cur.ipl || dev_rst_o !== cur.drst || pc_zero_o !== cur.drst ||
          cause_o !== cur.cause) begin
        errors++;
        $display("FAIL %s: act take=%b vec=%0d ipl=%0d drst=%b pcz=%b cause=%b exp take=%b vec=%0d ipl=%0d drst=%b pcz=%b cause=%b",
                 cur.req, take_trap_o, trap_vec_o, ipl_o, dev_rst_o, pc_zero_o, cause_o,
                 cur.take, cur.vec, cur.ipl, cur.drst, cur.drst, cur.cause);
      end
    end
  end

  task automatic idle_inputs();
    trap_req_i = '0; instr_done_i = 0; illegal_op_i = 0; flush_i = 0;
    uninit_ptr_i = 0; wdt_timeout_i = 0; bor_i = 0; trap_ret_i = 0;
    ipl_we_i = 0; ipl_wdata_i = '0; cause_clr_i = '0;
  endtask

  // driver: inputs already set at negedge; push expectation for after next edge
  task automatic expect_nxt(string req, logic take, logic [2:0] vec, logic [3:0] ipl,
                            logic drst, logic [4:0] cause);
    exp_t e;
    e.req = req; e.take = take; e.vec = vec; e.ipl = ipl; e.drst = drst; e.cause = cause;
    sb_q.push_back(e);
    @(posedge clk_i);
    @(negedge clk_i);
    idle_inputs();
  endtask

  task automatic direct(string req, logic pcz_exp);
    checks++;
    if (take_trap_o !== 0 || dev_rst_o !== 0 || ipl_o !== 0 || cause_o !== 0 || pc_zero_o !== pcz_exp) begin
      errors++;
      $display("FAIL %s: act take=%b drst=%b ipl=%0d cause=%b pcz=%b exp take=0 drst=0 ipl=0 cause=0 pcz=%b",
               req, take_trap_o, dev_rst_o, ipl_o, cause_o, pc_zero_o, pcz_exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    direct("R1 in reset", 1'b1);
    rst_ni = 1'b1;
    #1 direct("R1 after release", 1'b1);
    @(negedge clk_i);

    expect_nxt("R1 idle", 0, 0, 0, 0, 5'b00000);
    ipl_we_i = 1; ipl_wdata_i = 3'd7;
    expect_nxt("R5 sw level 7", 0, 0, 7, 0, 5'b00000);
    trap_req_i = 8'h04;
    expect_nxt("R2 pending only", 0, 0, 7, 0, 5'b00000);
    instr_done_i = 1;
    expect_nxt("R2 R3 R5 grant at level 7", 1, 2, 10, 0, 5'b00000);
    ipl_we_i = 1; ipl_wdata_i = 3'd3;
    expect_nxt("R5 write ignored in trap", 0, 0, 10, 0, 5'b00000);
    trap_ret_i = 1;
    expect_nxt("R6 return", 0, 0, 7, 0, 5'b00000);
    trap_req_i = 8'h02;
    expect_nxt("R4 pend bit1", 0, 0, 7, 0, 5'b00000);
    trap_req_i = 8'h20;
    expect_nxt("R4 pend bit5", 0, 0, 7, 0, 5'b00000);
    instr_done_i = 1;
    expect_nxt("R4 highest first", 1, 5, 13, 0, 5'b00000);
    instr_done_i = 1;
    expect_nxt("R4 R6 second grant nested", 1, 1, 9, 0, 5'b00000);
    trap_ret_i = 1;
    expect_nxt("R6 restore pre-trap level", 0, 0, 7, 0, 5'b00000);
    trap_req_i = 8'h09;
    expect_nxt("R7 lockout", 0, 0, 0, 1, 5'b10000);
    expect_nxt("R10 R11 pulse ends cause held", 0, 0, 0, 0, 5'b10000);
    cause_clr_i = 5'b10000;
    expect_nxt("R11 clear", 0, 0, 0, 0, 5'b00000);
    illegal_op_i = 1; flush_i = 1;
    expect_nxt("R9 flushed illegal", 0, 0, 0, 0, 5'b00000);
    illegal_op_i = 1;
    expect_nxt("R8 illegal", 0, 0, 0, 1, 5'b00100);
    wdt_timeout_i = 1;
    expect_nxt("R8 watchdog", 0, 0, 0, 1, 5'b00101);
    uninit_ptr_i = 1;
    expect_nxt("R8 uninit", 0, 0, 0, 1, 5'b00111);
    bor_i = 1;
    expect_nxt("R8 brown-out", 0, 0, 0, 1, 5'b01111);
    cause_clr_i = 5'b01111; wdt_timeout_i = 1;
    expect_nxt("R11 set wins over clear", 0, 0, 0, 1, 5'b00001);
    trap_req_i = 8'h10; instr_done_i = 1;
    expect_nxt("R2 done with request same cycle", 0, 0, 0, 0, 5'b00001);
    instr_done_i = 1;
    expect_nxt("R2 R3 grant bit4", 1, 4, 12, 0, 5'b00001);
    trap_ret_i = 1;
    expect_nxt("R6 back to 0", 0, 0, 0, 0, 5'b00001);
    trap_ret_i = 1;
    expect_nxt("R6 return outside trap", 0, 0, 0, 0, 5'b00001);
    trap_req_i = 8'h40; wdt_timeout_i = 1;
    expect_nxt("R10 request with reset", 0, 0, 0, 1, 5'b00001);
    instr_done_i = 1;
    expect_nxt("R10 request discarded", 0, 0, 0, 0, 5'b00001);
    trap_req_i = 8'h80;
    expect_nxt("R2 pend bit7", 0, 0, 0, 0, 5'b00001);
    instr_done_i = 1; bor_i = 1;
    expect_nxt("R10 grant suppressed", 0, 0, 0, 1, 5'b01001);
    instr_done_i = 1;
    expect_nxt("R10 pending discarded", 0, 0, 0, 0, 5'b01001);

    rst_ni = 1'b0;
    #1 direct("R1 R11 power-on clears causes", 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    direct("R1 strobe gone after first edge", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: act hung exp finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule